// File: doc/BRIEF.md
# Single-Cycle 32-bit RISC Core

This is a 32-bit processor core that fetches, decodes and completes one instruction in every clock cycle. It executes a fixed subset of nine instructions. Five are register-to-register arithmetic and logic operations: add, subtract, and, or, and signed set-less-than. The other four are load word, store word, branch-if-equal and an absolute jump. Everything else in the encoding space does nothing and the core moves on to the next word.

The core has two memory ports. The instruction port puts out a word address and takes back a 32-bit instruction in the same cycle. The data port puts out a byte address, write data, a read enable and a write enable, and takes back read data in the same cycle. The surrounding system supplies both memories. The memories must be combinational on read. The data memory must write on the rising edge at which `dmem_wr` is high. The program counter updates on the rising edge. The register file writes on the falling edge, so a result computed in the first half of a cycle is stored before the next instruction reads it.

Top module: `sc_core`

## Requirements
- R1: While `rst` is high at a rising edge, the PC is set to 0, so `imem_addr` reads 0. While `rst` is high, all 32 registers are cleared on falling edges, and `dmem_wr` and `dmem_rd` stay 0.
- R2: Instructions with opcode [31:26]=000000 use rs=[25:21], rt=[20:16], rd=[15:11] and funct=[5:0]. They write rs op rt into rd. The funct codes are 100000 add, 100010 subtract, 100100 and, 100101 or, and 101010 signed set-less-than, which gives 1 or 0. Results wrap modulo 2^32.
- R3: Opcode 100011 (load) drives `dmem_addr` = reg[rs] + sign-extended imm16 [15:0] and raises `dmem_rd`. It writes `dmem_rdata` into rt.
- R4: Opcode 101011 (store) drives the same address, puts reg[rt] on `dmem_wdata` and raises `dmem_wr`. It writes no register.
- R5: Opcode 000100 (branch-if-equal) sets the next PC to PC+4+(sign-extended imm16 × 4) when reg[rs]==reg[rt], and to PC+4 otherwise. The offset may be negative. It writes neither registers nor memory.
- R6: Opcode 000010 (jump) sets the next PC to {PC+4 bits [31:28], target [25:0], 00}.
- R7: Register 0 always reads as zero. Loads and arithmetic that name it as destination leave it at zero.
- R8: Every instruction other than a taken branch or a jump advances the PC by 4. `imem_addr` is PC bits [31:2].
- R9: `dmem_rd` is high only for loads and `dmem_wr` only for stores. They are never high together.
- R10: Any other opcode, and an opcode-000000 word with any other funct, writes no register, accesses no memory, and advances the PC by 4.
- R11: A register written by one instruction holds the new value when the very next instruction reads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock. PC on the rising edge, register file on the falling edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 30 | Word address of the current instruction |
| imem_data | input | 32 | Instruction word at `imem_addr` |
| dmem_addr | output | 32 | Byte address for loads and stores |
| dmem_wdata | output | 32 | Store data |
| dmem_rdata | input | 32 | Load data at `dmem_addr` |
| dmem_rd | output | 1 | High during a load |
| dmem_wr | output | 1 | High during a store; memory writes on the rising edge |

## Verification
Register contents are only visible through stores. Every scenario therefore first loads operands from preset data words, then stores its results so the bench can compare memory. The hardest cases to reach are a branch with a negative offset, and a write to register 0 that must leave it at zero. The bench builds small programs for both: a taken forward branch lands on a backward branch that re-enters skipped code, and a value stored from register 0 after a load and an add into it must read back as zero. Dependent back-to-back instructions check that the falling-edge write is in place before the next read. Illegal words are placed among real stores, and the bench samples the enables in their cycles to show that they have no effect.

// File: rtl/sc_core.sv
module sc_core #(
  parameter logic [31:0] RESET_PC = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  output logic [29:0] imem_addr,
  input  logic [31:0] imem_data,
  output logic [31:0] dmem_addr,
  output logic [31:0] dmem_wdata,
  input  logic [31:0] dmem_rdata,
  output logic        dmem_rd,
  output logic        dmem_wr
);
  localparam logic [5:0] OP_REG   = 6'b000000;
  localparam logic [5:0] OP_LOAD  = 6'b100011;
  localparam logic [5:0] OP_STORE = 6'b101011;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_JMP   = 6'b000010;
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;
  localparam logic [2:0] AC_AND = 3'b000;
  localparam logic [2:0] AC_OR  = 3'b001;
  localparam logic [2:0] AC_ADD = 3'b010;
  localparam logic [2:0] AC_SUB = 3'b110;
  localparam logic [2:0] AC_SLT = 3'b111;

  logic [31:0] pc, pc_plus4, br_tgt, jmp_tgt, next_pc;
  logic [31:0] rf [0:31];

  logic [5:0]  opc, fn;
  logic [4:0]  rs, rt, rd, wr_idx;
  logic [15:0] imm;
  logic [31:0] imm_ext, a_val, b_val, alu_b, alu_y, wr_val;
  logic        unused_shamt;

  logic        sel_rd, use_imm, from_mem, reg_wen, mem_rd, mem_wr, is_beq, is_jmp;
  logic [1:0]  alu_kind;
  logic [2:0]  alu_ctl;
  logic        fn_ok, alu_zero, take_br;

  assign opc     = imem_data[31:26];
  assign rs      = imem_data[25:21];
  assign rt      = imem_data[20:16];
  assign rd      = imem_data[15:11];
  assign fn      = imem_data[5:0];
  assign imm     = imem_data[15:0];
  assign imm_ext = {{16{imm[15]}}, imm};
  assign unused_shamt = ^imem_data[10:6];

  always_comb begin
    sel_rd   = 1'b0;
    use_imm  = 1'b0;
    from_mem = 1'b0;
    reg_wen  = 1'b0;
    mem_rd   = 1'b0;
    mem_wr   = 1'b0;
    is_beq   = 1'b0;
    is_jmp   = 1'b0;
    alu_kind = 2'b00;
    unique case (opc)
      OP_REG: begin
        sel_rd   = 1'b1;
        reg_wen  = 1'b1;
        alu_kind = 2'b10;
      end
      OP_LOAD: begin
        use_imm  = 1'b1;
        from_mem = 1'b1;
        reg_wen  = 1'b1;
        mem_rd   = 1'b1;
      end
      OP_STORE: begin
        use_imm = 1'b1;
        mem_wr  = 1'b1;
      end
      OP_BEQ: begin
        is_beq   = 1'b1;
        alu_kind = 2'b01;
      end
      OP_JMP: is_jmp = 1'b1;
      default: ;
    endcase
  end

  always_comb begin
    fn_ok   = 1'b1;
    alu_ctl = AC_ADD;
    case (alu_kind)
      2'b00: alu_ctl = AC_ADD;
      2'b01: alu_ctl = AC_SUB;
      default: begin
        case (fn)
          FN_ADD: alu_ctl = AC_ADD;
          FN_SUB: alu_ctl = AC_SUB;
          FN_AND: alu_ctl = AC_AND;
          FN_OR:  alu_ctl = AC_OR;
          FN_SLT: alu_ctl = AC_SLT;
          default: fn_ok = 1'b0;
        endcase
      end
    endcase
  end

  assign a_val = (rs == 5'd0) ? 32'd0 : rf[rs];
  assign b_val = (rt == 5'd0) ? 32'd0 : rf[rt];
  assign alu_b = use_imm ? imm_ext : b_val;

  always_comb begin
    case (alu_ctl)
      AC_AND:  alu_y = a_val & alu_b;
      AC_OR:   alu_y = a_val | alu_b;
      AC_SUB:  alu_y = a_val - alu_b;
      AC_SLT:  alu_y = {31'd0, $signed(a_val) < $signed(alu_b)};
      default: alu_y = a_val + alu_b;
    endcase
  end
  assign alu_zero = (alu_y == 32'd0);

  assign wr_idx = sel_rd ? rd : rt;
  assign wr_val = from_mem ? dmem_rdata : alu_y;

  always_ff @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) rf[i] <= 32'd0;
    end else if (reg_wen && fn_ok && wr_idx != 5'd0) begin
      rf[wr_idx] <= wr_val;
    end
  end

  assign pc_plus4 = pc + 32'd4;
  assign br_tgt   = pc_plus4 + {imm_ext[29:0], 2'b00};
  assign jmp_tgt  = {pc_plus4[31:28], imem_data[25:0], 2'b00};
  assign take_br  = is_beq && alu_zero;
  assign next_pc  = is_jmp ? jmp_tgt : (take_br ? br_tgt : pc_plus4);

  always_ff @(posedge clk) begin
    if (rst) pc <= RESET_PC;
    else     pc <= next_pc;
  end

  assign imem_addr  = pc[31:2];
  assign dmem_addr  = alu_y;
  assign dmem_wdata = b_val;
  assign dmem_rd    = mem_rd && !rst;
  assign dmem_wr    = mem_wr && !rst;

  p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> imem_addr == RESET_PC[31:2]);

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |-> (!dmem_wr && !dmem_rd));

  p_seq_pc_r8: assert property (@(posedge clk) disable iff (rst)
    (!is_beq && !is_jmp) |=> pc == $past(pc) + 32'd4);

  p_pc_aligned_r8: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  p_mem_excl_r9: assert property (@(posedge clk) disable iff (rst)
    !(dmem_rd && dmem_wr));

  p_zero_reg_r7: assert property (@(posedge clk) disable iff (rst)
    rf[0] == 32'd0);

  p_not_taken_r5: assert property (@(posedge clk) disable iff (rst)
    (is_beq && a_val != b_val) |=> pc == $past(pc) + 32'd4);
endmodule

// File: tb/sc_core_test.sv
module sc_core_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [29:0] imem_addr;
  logic [31:0] imem_data;
  logic [31:0] dmem_addr, dmem_wdata, dmem_rdata;
  logic        dmem_rd, dmem_wr;

  logic [31:0] imem [0:63];
  logic [31:0] dmem [0:63];
  int pc_n;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sc_core uut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_data(imem_data),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_rdata(dmem_rdata),
    .dmem_rd(dmem_rd), .dmem_wr(dmem_wr)
  );

  assign imem_data  = imem[imem_addr[5:0]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];
  always @(posedge clk) if (dmem_wr) dmem[dmem_addr[7:2]] <= dmem_wdata;

  function automatic logic [31:0] enc_r(int s, int t, int d, logic [5:0] f);
    return {6'b000000, s[4:0], t[4:0], d[4:0], 5'b00000, f};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int s, int t, int imm);
    return {op, s[4:0], t[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int tgt);
    return {6'b000010, tgt[25:0]};
  endfunction
  function automatic logic [31:0] lw(int t, int off, int s);
    return enc_i(6'b100011, s, t, off);
  endfunction
  function automatic logic [31:0] sw(int t, int off, int s);
    return enc_i(6'b101011, s, t, off);
  endfunction
  function automatic logic [31:0] beq(int s, int t, int off);
    return enc_i(6'b000100, s, t, off);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic new_prog();
    pc_n = 0;
    for (int i = 0; i < 64; i++) begin
      imem[i] = 32'd0;
      dmem[i] = 32'd0;
    end
  endtask
  task automatic put(logic [31:0] w);
    imem[pc_n] = w;
    pc_n++;
  endtask
  task automatic end_prog();
    put(enc_j(pc_n));
  endtask
  task automatic release_rst();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
  endtask
  task automatic run(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_arith();
    logic [31:0] a, b;
    a = 32'h0000_00F7;
    b = 32'hFFFF_FF0D;
    new_prog();
    dmem[32] = a;
    dmem[33] = b;
    put(lw(1, 128, 0));
    put(lw(2, 132, 0));
    put(enc_r(1, 2, 3, 6'b100000));
    put(enc_r(1, 2, 4, 6'b100010));
    put(enc_r(1, 2, 5, 6'b100100));
    put(enc_r(1, 2, 6, 6'b100101));
    put(enc_r(2, 1, 7, 6'b101010));
    put(enc_r(1, 2, 8, 6'b101010));
    put(enc_r(3, 3, 9, 6'b100000));
    put(sw(3, 0, 0));
    put(sw(4, 4, 0));
    put(sw(5, 8, 0));
    put(sw(6, 12, 0));
    put(sw(7, 16, 0));
    put(sw(8, 20, 0));
    put(sw(9, 24, 0));
    end_prog();
    release_rst();
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R8 pc step", {2'b00, imem_addr}, k);
      chk("R9 read enable", {31'd0, dmem_rd}, (k < 2) ? 1 : 0);
      chk("R9 write enable", {31'd0, dmem_wr}, 0);
    end
    run(20);
    chk("R2 add", dmem[0], a + b);
    chk("R2 sub", dmem[1], a - b);
    chk("R2 and", dmem[2], a & b);
    chk("R2 or", dmem[3], a | b);
    chk("R2 slt true", dmem[4], 1);
    chk("R2 slt false", dmem[5], 0);
    chk("R11 back-to-back", dmem[6], (a + b) + (a + b));
  endtask

  task automatic t_reset();
    new_prog();
    dmem[0] = 32'hDEAD_BEEF;
    put(sw(5, 0, 0));
    end_prog();
    rst = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 pc zero", {2'b00, imem_addr}, 0);
    chk("R1 no store in reset", {31'd0, dmem_wr}, 0);
    @(posedge clk);
    #1;
    chk("R1 memory untouched", dmem[0], 32'hDEAD_BEEF);
    rst = 1'b0;
    run(4);
    chk("R1 registers cleared", dmem[0], 0);
  endtask

  task automatic t_ldst();
    new_prog();
    dmem[32] = 32'd144;
    dmem[35] = 32'h1234_5678;
    put(lw(9, 128, 0));
    put(lw(10, -4, 9));
    put(sw(10, 8, 9));
    end_prog();
    release_rst();
    @(negedge clk);
    @(negedge clk);
    chk("R3 load address", dmem_addr, 140);
    chk("R3 load enable", {31'd0, dmem_rd}, 1);
    @(negedge clk);
    chk("R4 store address", dmem_addr, 152);
    chk("R4 store data", dmem_wdata, 32'h1234_5678);
    chk("R4 store enable", {30'd0, dmem_wr, dmem_rd}, 2);
    run(4);
    chk("R4 stored word", dmem[38], 32'h1234_5678);
  endtask

  task automatic t_branch();
    new_prog();
    dmem[32] = 5;
    dmem[33] = 5;
    dmem[34] = 6;
    put(lw(1, 128, 0));
    put(lw(2, 132, 0));
    put(lw(3, 136, 0));
    put(beq(1, 2, 2));
    put(sw(1, 0, 0));
    put(enc_j(8));
    put(sw(1, 8, 0));
    put(beq(0, 0, -4));
    put(beq(1, 3, 1));
    put(sw(3, 12, 0));
    end_prog();
    release_rst();
    repeat (5) @(negedge clk);
    chk("R5 forward taken", {2'b00, imem_addr}, 6);
    repeat (2) @(negedge clk);
    chk("R5 backward taken", {2'b00, imem_addr}, 4);
    run(12);
    chk("R5 re-entered word", dmem[0], 5);
    chk("R5 skipped word", dmem[1], 0);
    chk("R5 target word", dmem[2], 5);
    chk("R5 not taken", dmem[3], 6);
  endtask

  task automatic t_jump();
    new_prog();
    dmem[32] = 32'h0BAD_F00D;
    put(lw(1, 128, 0));
    put(enc_j(5));
    put(sw(1, 0, 0));
    put(sw(1, 4, 0));
    put(enc_j(4));
    put(sw(1, 8, 0));
    end_prog();
    release_rst();
    repeat (3) @(negedge clk);
    chk("R6 jump target", {2'b00, imem_addr}, 5);
    run(6);
    chk("R6 skipped", dmem[0], 0);
    chk("R6 landed", dmem[2], 32'h0BAD_F00D);
  endtask

  task automatic t_zero();
    new_prog();
    dmem[32] = 32'h5555_AAAA;
    dmem[33] = 32'h0000_0011;
    put(lw(0, 128, 0));
    put(lw(1, 132, 0));
    put(enc_r(1, 1, 0, 6'b100000));
    put(sw(0, 0, 0));
    put(enc_r(0, 1, 2, 6'b100000));
    put(sw(2, 4, 0));
    end_prog();
    dmem[0] = 32'hFFFF_FFFF;
    release_rst();
    run(9);
    chk("R7 zero register", dmem[0], 0);
    chk("R7 zero operand", dmem[1], 32'h11);
  endtask

  task automatic t_illegal();
    new_prog();
    dmem[32] = 32'h0000_4321;
    put(lw(3, 128, 0));
    put(enc_i(6'b001000, 0, 3, 5));
    put(enc_r(3, 3, 3, 6'b000000));
    put(enc_i(6'b100000, 0, 3, 128));
    put(enc_i(6'b101000, 0, 3, 0));
    put(sw(3, 4, 0));
    end_prog();
    dmem[0] = 32'hCAFE_0001;
    release_rst();
    @(negedge clk);
    for (int k = 1; k < 5; k++) begin
      @(negedge clk);
      chk("R10 pc advance", {2'b00, imem_addr}, k);
      chk("R10 no access", {30'd0, dmem_wr, dmem_rd}, 0);
    end
    run(6);
    chk("R10 register kept", dmem[1], 32'h0000_4321);
    chk("R10 memory kept", dmem[0], 32'hCAFE_0001);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_arith();
    t_reset();
    t_ldst();
    t_branch();
    t_jump();
    t_zero();
    t_illegal();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule